// File: doc/BRIEF.md
# Indexed Register Window for an Interrupt Redirection Table

This block is the register-facing front end of an I/O interrupt redirection controller that serves 24 input pins. Software reaches every register through two bus offsets. It first writes an 8-bit register index through the select offset. It then reads or writes the chosen register through the window offset. Behind the window sit a 4-bit controller identifier, a read-only version word and one 64-bit redirection entry per pin. Each entry is reached as two 32-bit halves at neighbouring indexes.

The block also works with the delivery logic beside it. That logic reports, through a set input, when a level interrupt is in service. The block records this in the entry's remote-IRR bit (bit 14 of the lower half), and a software write to the lower half clears that bit. Whenever a write flips an entry's mask bit (bit 16), the block emits a one-cycle notice with the pin number and the new mask value. After every accepted entry write, the block emits a one-cycle recheck strobe with the pin number, so that the delivery logic can service a level interrupt that is still pending.

Top module: `irq_route_window`

## Requirements
- R1: Only `bus_addr[7:0]` is decoded. Offset 0x00 is the select register and offset 0x10 is the data window. A select read returns the index in bits 7:0. Reads of any other offset return zero, and writes to any other offset change nothing.
- R2: A write to the select offset loads the low 8 bits of the extended write data into the index register.
- R3: `bus_size` 0 is a byte, 1 is a halfword, and 2 or 3 is a word. Byte and halfword write data are zero-extended to 32 bits before any use.
- R4: Index 0x01 reads as the version word: (pin count − 1) in bits 23:16, the version parameter in bits 7:0, and zeros elsewhere. Writes to index 0x01 have no effect.
- R5: Index 0x00 and index 0x02 both read the 4-bit controller ID in bits 27:24, with zeros elsewhere. A write to index 0x00 loads the ID from data bits 27:24. Writes to index 0x02 have no effect.
- R6: For an index of 0x10 or above, the entry number is (index − 0x10) >> 1. An odd index reaches entry bits 63:32 and an even index reaches bits 31:0.
- R7: An entry number at or beyond the pin count reads as all ones, and a write to it is dropped with no strobe. Indexes 0x03 to 0x0F behave the same way.
- R8: The remote-IRR bit (entry bit 14) is set by `rirr_set` for pin `rirr_pin`. It is cleared by any write to that entry's lower half, whatever the data bit. Upper-half writes leave it unchanged.
- R9: When a lower-half write changes an entry's mask bit (entry bit 16), `mask_chg_valid` is high for exactly the next cycle, with `mask_chg_pin` and the new value on `mask_chg_value`. A write that leaves the mask bit unchanged raises no notice.
- R10: Every accepted entry write, to either half, raises `reeval_valid` for exactly the next cycle, with `reeval_pin` naming the entry. Writes to non-entry indexes raise no strobe.
- R11: Reset sets every entry to mask-only (lower half 0x0001_0000, upper half 0), and clears the index register and the ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset; only bits 7:0 decoded |
| bus_size | input | 2 | Write width: 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as a read access |
| rirr_set | input | 1 | Delivery logic marks a level interrupt in service |
| rirr_pin | input | PIN_W | Pin whose remote-IRR bit is set |
| mask_chg_valid | output | 1 | Mask bit of an entry changed |
| mask_chg_pin | output | PIN_W | Pin whose mask changed |
| mask_chg_value | output | 1 | New mask value |
| reeval_valid | output | 1 | Entry written; recheck pending level interrupt |
| reeval_pin | output | PIN_W | Pin of the written entry |

## Verification
The bench sweeps all 256 indexes after reset, after a full pass of writes to every entry half, and at the end. It compares each read with a model of the index arithmetic, so a design that decodes the entry number or the half wrongly, or that misplaces the version or ID fields, returns the wrong word at some index. It targets the edge of the table at index 0x3F/0x40 and the gap at 0x03–0x0F, where a design that wraps the entry number would alias a real entry instead of reading all ones and dropping the write. It also covers remote-IRR survival across upper-half writes with clearing on lower-half writes, mask notices raised only on a real flip, and zero-extension of narrow writes, which would corrupt the index or the ID if left out.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

  localparam logic [7:0] OFF_SELECT = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;
  localparam logic [7:0] IDX_ID     = 8'h00;
  localparam logic [7:0] IDX_VER    = 8'h01;
  localparam logic [7:0] IDX_ARB    = 8'h02;
  localparam logic [7:0] ENTRY_BASE = 8'h10;
  localparam int unsigned MASK_BIT  = 16;
  localparam int unsigned RIRR_BIT  = 14;
  localparam logic [63:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

  // Zero-extend a narrow write to 32 bits.
  function automatic logic [31:0] widen(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'h0, d[7:0]};
      2'd1:    return {16'h0, d[15:0]};
      default: return d;
    endcase
  endfunction

  // Read-only identification word.
  function automatic logic [31:0] version_word(input int unsigned npins, input logic [7:0] ver);
    return {8'h00, 8'(npins - 1), 8'h00, ver};
  endfunction

  // Lower half as stored after a software write: remote-IRR forced low.
  function automatic logic [31:0] lo_after_write(input logic [31:0] d);
    logic [31:0] r;
    r = d;
    r[RIRR_BIT] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/iwin_decode.sv
module iwin_decode
  import iwin_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NPINS  = 24,
  parameter int unsigned PIN_W  = 5
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  input  logic [7:0]        index,
  output logic              wr_select,
  output logic              wr_window,
  output logic              rd_select,
  output logic              rd_window,
  output logic [31:0]       wdata_ext,
  output logic              is_id,
  output logic              is_ver,
  output logic              is_arb,
  output logic              ent_hit,
  output logic [PIN_W-1:0]  ent_pin,
  output logic              ent_hi
);
  logic [7:0] off;
  logic [7:0] rel;
  logic [6:0] ent_num;
  logic       unused_addr_hi;

  assign off            = bus_addr[7:0];
  assign unused_addr_hi = ^bus_addr[ADDR_W-1:8];

  assign wr_select = bus_sel &&  bus_we && (off == OFF_SELECT);
  assign wr_window = bus_sel &&  bus_we && (off == OFF_WINDOW);
  assign rd_select = bus_sel && !bus_we && (off == OFF_SELECT);
  assign rd_window = bus_sel && !bus_we && (off == OFF_WINDOW);
  assign wdata_ext = widen(bus_wdata, bus_size);

  assign is_id  = (index == IDX_ID);
  assign is_ver = (index == IDX_VER);
  assign is_arb = (index == IDX_ARB);

  assign rel     = index - ENTRY_BASE;
  assign ent_num = rel[7:1];
  assign ent_hi  = rel[0];
  assign ent_pin = ent_num[PIN_W-1:0];
  assign ent_hit = (index >= ENTRY_BASE) && ({1'b0, ent_num} < 8'(NPINS));

endmodule

// File: rtl/iwin_table.sv
module iwin_table
  import iwin_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  parameter int unsigned PIN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_hi,
  input  logic [PIN_W-1:0] wr_pin,
  input  logic [31:0]      wr_data,
  input  logic             rirr_set,
  input  logic [PIN_W-1:0] rirr_pin,
  input  logic [PIN_W-1:0] rd_pin,
  input  logic             rd_hi,
  output logic [31:0]      rd_data,
  output logic             mask_chg_valid,
  output logic [PIN_W-1:0] mask_chg_pin,
  output logic             mask_chg_value,
  output logic             reeval_valid,
  output logic [PIN_W-1:0] reeval_pin
);
  logic [NPINS-1:0][63:0] ent_q;
  logic                   cur_mask;
  logic                   mask_flip;
  logic                   rd_in_range;
  logic                   set_in_range;

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic [63:0] q;
    logic        hit_w;
    logic        hit_s;
    assign hit_w = wr_en && (wr_pin == PIN_W'(g));
    assign hit_s = rirr_set && (rirr_pin == PIN_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= ENTRY_RESET;
      end else begin
        if (hit_w && wr_hi)  q[63:32] <= wr_data;
        if (hit_w && !wr_hi) q[31:0]  <= lo_after_write(wr_data);
        if (hit_s)           q[RIRR_BIT] <= 1'b1;
      end
    end
    assign ent_q[g] = q;
  end

  assign rd_in_range  = ({1'b0, rd_pin} < (PIN_W+1)'(NPINS));
  assign set_in_range = ({1'b0, rirr_pin} < (PIN_W+1)'(NPINS));
  assign rd_data = !rd_in_range ? '1 :
                   rd_hi ? ent_q[rd_pin][63:32] : ent_q[rd_pin][31:0];

  assign cur_mask  = ent_q[wr_pin][MASK_BIT];
  assign mask_flip = wr_en && !wr_hi && (wr_data[MASK_BIT] != cur_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_chg_valid <= 1'b0;
      mask_chg_pin   <= '0;
      mask_chg_value <= 1'b0;
      reeval_valid   <= 1'b0;
      reeval_pin     <= '0;
    end else begin
      mask_chg_valid <= mask_flip;
      mask_chg_pin   <= wr_pin;
      mask_chg_value <= wr_data[MASK_BIT];
      reeval_valid   <= wr_en;
      reeval_pin     <= wr_pin;
    end
  end

  // R8
  rirr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi && !(rirr_set && rirr_pin == wr_pin)) |=> !ent_q[$past(wr_pin)][RIRR_BIT]);
  // R8
  rirr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_set && set_in_range) |=> ent_q[$past(rirr_pin)][RIRR_BIT]);
  // R9
  mask_notice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_chg_valid |-> (ent_q[mask_chg_pin][MASK_BIT] == mask_chg_value));
  // R10
  reeval_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (reeval_valid && reeval_pin == $past(wr_pin)));
  // R10
  reeval_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !reeval_valid);

endmodule

// File: rtl/irq_route_window.sv
module irq_route_window
  import iwin_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NPINS   = 24,
  parameter logic [7:0]  VERSION = 8'h11,
  localparam int unsigned PIN_W  = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rirr_set,
  input  logic [PIN_W-1:0]  rirr_pin,
  output logic              mask_chg_valid,
  output logic [PIN_W-1:0]  mask_chg_pin,
  output logic              mask_chg_value,
  output logic              reeval_valid,
  output logic [PIN_W-1:0]  reeval_pin
);
  logic [7:0]       index_q;
  logic [3:0]       id_q;
  logic             wr_select, wr_window, rd_select, rd_window;
  logic [31:0]      wdata_ext;
  logic             is_id, is_ver, is_arb, ent_hit, ent_hi;
  logic [PIN_W-1:0] ent_pin;
  logic             tbl_wr_en;
  logic [31:0]      tbl_rdata;
  logic [31:0]      window_rdata;

  iwin_decode #(.ADDR_W(ADDR_W), .NPINS(NPINS), .PIN_W(PIN_W)) u_dec (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .index(index_q),
    .wr_select(wr_select), .wr_window(wr_window), .rd_select(rd_select), .rd_window(rd_window),
    .wdata_ext(wdata_ext), .is_id(is_id), .is_ver(is_ver), .is_arb(is_arb),
    .ent_hit(ent_hit), .ent_pin(ent_pin), .ent_hi(ent_hi)
  );

  assign tbl_wr_en = wr_window && ent_hit;

  iwin_table #(.NPINS(NPINS), .PIN_W(PIN_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en), .wr_hi(ent_hi), .wr_pin(ent_pin), .wr_data(wdata_ext),
    .rirr_set(rirr_set), .rirr_pin(rirr_pin),
    .rd_pin(ent_pin), .rd_hi(ent_hi), .rd_data(tbl_rdata),
    .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin), .mask_chg_value(mask_chg_value),
    .reeval_valid(reeval_valid), .reeval_pin(reeval_pin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      id_q    <= '0;
    end else begin
      if (wr_select)           index_q <= wdata_ext[7:0];
      if (wr_window && is_id)  id_q    <= wdata_ext[27:24];
    end
  end

  always_comb begin
    if (is_ver)                window_rdata = version_word(NPINS, VERSION);
    else if (is_id || is_arb)  window_rdata = {4'h0, id_q, 24'h0};
    else if (ent_hit)          window_rdata = tbl_rdata;
    else                       window_rdata = '1;
  end

  assign bus_rdata = rd_select ? {24'h0, index_q} :
                     rd_window ? window_rdata : 32'h0;

  // R2
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_select |=> $stable(index_q));
  // R5
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_window && is_id) |=> $stable(id_q));
  // R1
  other_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_select || rd_window) |-> (bus_rdata == 32'h0));

  // R7
  always_comb begin
    if (rst_n && rd_window && !is_id && !is_ver && !is_arb && !ent_hit)
      idx_miss_chk: assert (bus_rdata == 32'hFFFF_FFFF);
  end

endmodule

// File: tb/tb_irq_route_window.sv
module tb_irq_route_window;
  localparam int NPINS = 24;
  localparam int PW    = 5;
  localparam int AW    = 12;
  localparam logic [7:0] VER = 8'h11;
  localparam logic [AW-1:0] SEL = 12'h000;
  localparam logic [AW-1:0] WIN = 12'h010;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_size = 2'd2;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          rirr_set = 1'b0;
  logic [PW-1:0] rirr_pin = '0;
  logic          mask_chg_valid, mask_chg_value, reeval_valid;
  logic [PW-1:0] mask_chg_pin, reeval_pin;

  irq_route_window dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rirr_set(rirr_set), .rirr_pin(rirr_pin),
    .mask_chg_valid(mask_chg_valid), .mask_chg_pin(mask_chg_pin), .mask_chg_value(mask_chg_value),
    .reeval_valid(reeval_valid), .reeval_pin(reeval_pin)
  );

  int checks = 0, errors = 0;
  logic [31:0] mlo [NPINS];
  logic [31:0] mhi [NPINS];
  logic [3:0]  mid;
  logic          cap_mv, cap_mval, cap_rv;
  logic [PW-1:0] cap_mp, cap_rp;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ext(input logic [31:0] d, input logic [1:0] s);
    if (s == 2'd0) return d & 32'h0000_00FF;
    if (s == 2'd1) return d & 32'h0000_FFFF;
    return d;
  endfunction

  function automatic logic [31:0] exp_win(input logic [7:0] idx);
    int n;
    n = (int'(idx) - 16) >>> 1;
    if (idx == 8'd0 || idx == 8'd2) return {4'h0, mid, 24'h0};
    if (idx == 8'd1) return {8'h00, 8'(NPINS - 1), 8'h00, VER};
    if (idx >= 8'd16 && n < NPINS) return idx[0] ? mhi[n] : mlo[n];
    return 32'hFFFF_FFFF;
  endfunction

  function automatic string tag(input logic [7:0] idx);
    if (idx == 8'd1) return "R4 version read";
    if (idx == 8'd0 || idx == 8'd2) return "R5 id read";
    if (idx >= 8'd16 && ((int'(idx) - 16) >>> 1) < NPINS) return "R6 entry read";
    return "R7 out-of-range read";
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
    @(negedge clk);
    cap_mv = mask_chg_valid; cap_mp = mask_chg_pin; cap_mval = mask_chg_value;
    cap_rv = reeval_valid;   cap_rp = reeval_pin;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic sweep(input string phase);
    logic [31:0] r;
    for (int i = 0; i < 256; i++) begin
      bus_write(SEL, 2'd2, 32'(i));
      bus_read(SEL, r);
      check({phase, " R2 select readback"}, r, 32'(i));
      bus_read(WIN, r);
      check({phase, " ", tag(8'(i))}, r, exp_win(8'(i)));
    end
  endtask

  task automatic ent_write(input logic [7:0] idx, input logic [1:0] s, input logic [31:0] d);
    logic [31:0] e, nl;
    int n;
    e = ext(d, s);
    n = (int'(idx) - 16) >>> 1;
    bus_write(SEL, 2'd2, {24'h0, idx});
    bus_write(WIN, s, d);
    if (idx >= 8'd16 && n < NPINS) begin
      check("R10 recheck strobe", 32'(cap_rv), 32'd1);
      check("R10 recheck pin", 32'(cap_rp), 32'(n));
      if (!idx[0]) begin
        nl = e & ~32'h0000_4000;
        check("R9 mask notice", 32'(cap_mv), 32'(nl[16] != mlo[n][16]));
        if (nl[16] != mlo[n][16]) begin
          check("R9 mask pin", 32'(cap_mp), 32'(n));
          check("R9 mask value", 32'(cap_mval), 32'(nl[16]));
        end
        mlo[n] = nl;
      end else begin
        check("R9 no notice on upper half", 32'(cap_mv), 32'd0);
        mhi[n] = e;
      end
    end else begin
      check("R7 dropped write no strobe", 32'(cap_rv), 32'd0);
      check("R7 dropped write no notice", 32'(cap_mv), 32'd0);
    end
  endtask

  task automatic set_rirr(input int p);
    @(negedge clk);
    rirr_set = 1'b1; rirr_pin = PW'(p);
    @(negedge clk);
    rirr_set = 1'b0;
    mlo[p] = mlo[p] | 32'h0000_4000;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < NPINS; i++) begin
      mlo[i] = 32'h0001_0000;
      mhi[i] = 32'h0;
    end
    mid = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 no mask notice", 32'(mask_chg_valid), 32'd0);
    check("R11 no strobe", 32'(reeval_valid), 32'd0);
    bus_read(SEL, r);
    check("R11 index cleared", r, 32'h0);
    sweep("R11 reset");

    // R6 R9 R10 fill every entry half; odd pins unmask
    for (int n = 0; n < NPINS; n++) begin
      ent_write(8'(16 + 2*n + 1), 2'd2, {8'(n), 24'h0} ^ 32'h00C3_5A00);
      ent_write(8'(16 + 2*n), 2'd2,
                (32'(n) << 24) | (32'(~n & 1) << 16) | 32'h0000_4000 | 32'(n + 32));
    end
    // R9 rewrite with same mask: no notice
    ent_write(8'h10, 2'd2, 32'h0001_0077);
    // R7 dropped writes at the table edge and in the gap
    ent_write(8'h40, 2'd2, 32'h1234_5678);
    ent_write(8'h41, 2'd2, 32'h1234_5678);
    ent_write(8'h05, 2'd2, 32'h0000_0000);
    sweep("R6 filled");

    // R5 ID and R4 version
    bus_write(SEL, 2'd2, 32'h0);
    bus_write(WIN, 2'd2, 32'hF5A5_A5A5);
    mid = 4'h5;
    check("R10 no strobe on id write", 32'(cap_rv), 32'd0);
    bus_read(WIN, r); check("R5 id via 0x00", r, 32'h0500_0000);
    bus_write(SEL, 2'd2, 32'h2);
    bus_read(WIN, r); check("R5 id via 0x02", r, 32'h0500_0000);
    bus_write(WIN, 2'd2, 32'h0C00_0000);
    bus_read(WIN, r); check("R5 arb write ignored", r, 32'h0500_0000);
    bus_write(SEL, 2'd2, 32'h1);
    bus_write(WIN, 2'd2, 32'hFFFF_FFFF);
    bus_read(WIN, r); check("R4 version write ignored", r, {8'h00, 8'(NPINS-1), 8'h00, VER});

    // R3 zero extension
    bus_write(SEL, 2'd0, 32'hABCD_1234);
    bus_read(SEL, r); check("R3 byte select write", r, 32'h34);
    bus_write(SEL, 2'd2, 32'hABCD_1217);
    bus_read(SEL, r); check("R2 select low byte", r, 32'h17);
    bus_write(SEL, 2'd2, 32'h0);
    bus_write(WIN, 2'd0, 32'hFF00_0000);
    mid = 4'h0;
    bus_read(WIN, r); check("R3 byte id write zero-extended", r, 32'h0);
    ent_write(8'h13, 2'd1, 32'hFFFF_FFFF);
    ent_write(8'h12, 2'd1, 32'hFFFF_FFFF);
    bus_write(SEL, 2'd2, 32'h12);
    bus_read(WIN, r); check("R3 halfword entry write", r, 32'h0000_BFFF);

    // R8 remote-IRR
    set_rirr(3);
    set_rirr(7);
    bus_write(SEL, 2'd2, 32'h16);
    bus_read(WIN, r); check("R8 set visible", r, mlo[3]);
    check("R8 bit14 set", 32'(r[14]), 32'd1);
    ent_write(8'h17, 2'd2, 32'h0F0F_0F0F);
    bus_write(SEL, 2'd2, 32'h16);
    bus_read(WIN, r); check("R8 kept over upper write", 32'(r[14]), 32'd1);
    ent_write(8'h16, 2'd2, 32'h0001_4055);
    bus_write(SEL, 2'd2, 32'h16);
    bus_read(WIN, r); check("R8 cleared by lower write", r, 32'h0001_0055);
    bus_write(SEL, 2'd2, 32'h1E);
    bus_read(WIN, r); check("R8 other pin kept", 32'(r[14]), 32'd1);

    // R1 offsets and address aliasing
    bus_write(12'h300, 2'd2, 32'h45);
    bus_read(12'hF00, r); check("R1 select alias", r, 32'h45);
    bus_read(12'h710, r); check("R1 window alias", r, 32'hFFFF_FFFF);
    bus_read(12'h004, r); check("R1 other offset reads zero", r, 32'h0);
    bus_write(12'h020, 2'd2, 32'h33);
    check("R1 other offset no strobe", 32'(cap_rv), 32'd0);
    bus_read(SEL, r); check("R1 other offset write ignored", r, 32'h45);

    sweep("R6 final");
    finish_run();
  end

endmodule